// File: doc/BRIEF.md
# Base-plus-symbol dispatch lane

This block is one programmable decoding lane. It reads a byte stream as a run of variable-width symbols, most significant bit first. Each step takes the current symbol and adds it to the base address of the current state, and reads the transition word found there in a packed transition memory. The word's stored signature must equal the identifier of the current state. On a match the word is used. Otherwise the lane falls back to the state's default word at base plus zero. No branch-target table is kept and nothing is predicted.

The chosen word supplies four things: the next state's base and identifier, the width of the next symbol, and an action. The action may load or accumulate a data register, store that register to a scratchpad through an auto-incrementing write port, or halt the lane. Tables from different states may be interleaved in one memory. Software fills the memory through a loader port, then pulses start.

Top module: `dispatch_lane`

## Requirements
- R1: A dispatch reads address (base + symbol) mod 256. The word is taken when its signature field, bits [3:0], equals the current state identifier. The other fields are next base [11:4], next identifier [15:12], width code [17:16] and action [20:18].
- R2: When the signature does not match, the lane takes the word at base + 0 instead.
- R3: Once enough bits are buffered, each dispatch takes exactly two clock cycles, so stores from consecutive dispatches come two cycles apart.
- R4: Width codes 0, 1, 2 and 3 select symbols of 1, 2, 4 and 8 bits, taken MSB-first from the stream. The width for the next symbol comes from the word just taken. The first symbol after start uses INIT_WCODE, which defaults to 1 (2 bits). The lane starts in base 0, identifier 0.
- R5: The bit buffer holds at most 16 bits. in_ready is high only while the lane runs, the stream has not ended, and at most 8 bits are buffered.
- R6: Action codes: 0 does nothing; 1 loads the register with the symbol; 2 adds the symbol to the register modulo 2^DATA_W; 3 writes the register to the scratchpad and advances the write address, which starts at 0; 4 halts.
- R7: Halt raises done. done stays high until the next start, and while it is high there are no writes and in_ready is low.
- R8: If the stream has ended (in_last accepted) and fewer bits remain than the next width needs, the lane stops. It raises underflow, keeps done low and makes no further writes.
- R9: After reset, done, underflow, in_ready and sp_we are low.
- R10: A start accepted while idle clears the register, the write address, the bit buffer, done and underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_we | input | 1 | Transition memory write strobe |
| ld_addr | input | 8 | Transition memory write address |
| ld_word | input | 21 | Transition word to write |
| start | input | 1 | Begin decoding (accepted while idle) |
| done | output | 1 | Halt reached |
| underflow | output | 1 | Stream ran out before halt |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Lane accepts a byte this cycle |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final stream byte |
| sp_we | output | 1 | Scratchpad write strobe |
| sp_addr | output | SP_AW | Scratchpad write address |
| sp_data | output | DATA_W | Scratchpad write data |

## Verification
The assertions assume that start is pulsed only while the lane is idle or has finished, and that the transition memory is not rewritten during a run. The bench fills every memory word before the first start and pulses start only after done or underflow. It presents stream bytes only through the valid/ready handshake, and flags in_last only on the final byte. The table under test is a run-length expander, and stream padding is zero bits. After the last tag, that padding can only lead to an underflow or a harmless tag, never to a store.

// File: rtl/dl_pkg.sv
package dl_pkg;
    localparam int XA_W  = 8;
    localparam int SIG_W = 4;

    typedef enum logic [2:0] {
        ACT_NOP   = 3'd0,
        ACT_LOAD  = 3'd1,
        ACT_ADD   = 3'd2,
        ACT_STORE = 3'd3,
        ACT_HALT  = 3'd4
    } act_e;

    typedef struct packed {
        act_e             act;
        logic [1:0]       wcode;
        logic [SIG_W-1:0] next_id;
        logic [XA_W-1:0]  next_base;
        logic [SIG_W-1:0] sig;
    } xword_t;

    localparam int XW_W = $bits(xword_t);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ACT} lane_st_e;

    function automatic logic [3:0] wcode_bits(input logic [1:0] code);
        return 4'd1 << code;
    endfunction
endpackage

// File: rtl/dl_bitfetch.sv
module dl_bitfetch #(
    parameter int BUF_W = 16,
    localparam int CNT_W = $clog2(BUF_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             enable,
    input  logic [3:0]       wbits,
    input  logic             take,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             have,
    output logic             starved,
    output logic [7:0]       sym,
    output logic [CNT_W-1:0] bit_cnt
);
    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
        logic             ended;
    } fb_t;

    fb_t q, d;
    logic             accept;
    logic [CNT_W-1:0] shamt;
    logic [BUF_W-1:0] mask;

    always_comb begin
        in_ready = enable && !q.ended && (q.cnt <= CNT_W'(BUF_W - 8));
        accept   = in_ready && in_valid;
        have     = q.cnt >= CNT_W'(wbits);
        starved  = q.ended && !have;
        shamt    = q.cnt - CNT_W'(wbits);
        mask     = (BUF_W'(1) << wbits) - BUF_W'(1);
        sym      = 8'((q.bits >> shamt) & mask);
        bit_cnt  = q.cnt;

        d = q;
        if (take)
            d.cnt = d.cnt - CNT_W'(wbits);
        if (accept) begin
            d.bits  = {q.bits[BUF_W-9:0], in_data};
            d.cnt   = d.cnt + CNT_W'(8);
            d.ended = in_last;
        end
        if (flush) begin
            d.cnt   = '0;
            d.ended = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dl_xmem.sv
module dl_xmem #(
    parameter int AW = 8,
    parameter int WW = 21
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    output logic [WW-1:0] qa,
    output logic [WW-1:0] qb
);
    logic [WW-1:0] mem [2**AW];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        qa <= mem[ra];
        qb <= mem[rb];
    end
endmodule

// File: rtl/dispatch_lane.sv
module dispatch_lane
    import dl_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SP_AW      = 6,
    parameter int BUF_W      = 16,
    parameter logic [1:0] INIT_WCODE = 2'd1,
    localparam int CNT_W = $clog2(BUF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [XA_W-1:0]   ld_addr,
    input  logic [XW_W-1:0]   ld_word,
    input  logic              start,
    output logic              done,
    output logic              underflow,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              sp_we,
    output logic [SP_AW-1:0]  sp_addr,
    output logic [DATA_W-1:0] sp_data
);
    typedef struct packed {
        lane_st_e          state;
        logic [XA_W-1:0]   base;
        logic [SIG_W-1:0]  id;
        logic [1:0]        wcode;
        logic [DATA_W-1:0] rval;
        logic [SP_AW-1:0]  ptr;
        logic [7:0]        sym;
        logic              done;
        logic              uf;
        logic              sp_we;
        logic [SP_AW-1:0]  sp_addr;
        logic [DATA_W-1:0] sp_data;
    } lane_t;

    lane_t q, d;

    logic             take, have, starved, flush, busy, in_act;
    logic [7:0]       fsym;
    logic [CNT_W-1:0] bit_cnt;
    logic [XA_W-1:0]  ra, rb;
    logic [XW_W-1:0]  qa_raw, qb_raw;
    xword_t           wa, wb, sel;

    assign busy   = (q.state != ST_IDLE);
    assign in_act = (q.state == ST_ACT);
    assign flush  = (q.state == ST_IDLE) && start;

    dl_bitfetch #(.BUF_W(BUF_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .flush(flush), .enable(busy),
        .wbits(wcode_bits(q.wcode)), .take(take),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .have(have), .starved(starved),
        .sym(fsym), .bit_cnt(bit_cnt)
    );

    dl_xmem #(.AW(XA_W), .WW(XW_W)) u_xmem (
        .clk(clk), .we(ld_we), .waddr(ld_addr), .wdata(ld_word),
        .ra(ra), .rb(rb), .qa(qa_raw), .qb(qb_raw)
    );

    always_comb begin
        wa   = xword_t'(qa_raw);
        wb   = xword_t'(qb_raw);
        sel  = (wa.sig == q.id) ? wa : wb;
        ra   = q.base + XA_W'(fsym);
        rb   = q.base;
        take = 1'b0;

        d       = q;
        d.sp_we = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_RUN;
                    d.base  = '0;
                    d.id    = '0;
                    d.wcode = INIT_WCODE;
                    d.rval  = '0;
                    d.ptr   = '0;
                    d.done  = 1'b0;
                    d.uf    = 1'b0;
                end
            end
            ST_RUN: begin
                if (have) begin
                    take    = 1'b1;
                    d.sym   = fsym;
                    d.state = ST_ACT;
                end else if (starved) begin
                    d.uf    = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            ST_ACT: begin
                case (sel.act)
                    ACT_LOAD:  d.rval = DATA_W'(q.sym);
                    ACT_ADD:   d.rval = q.rval + DATA_W'(q.sym);
                    ACT_STORE: begin
                        d.sp_we   = 1'b1;
                        d.sp_addr = q.ptr;
                        d.sp_data = q.rval;
                        d.ptr     = q.ptr + SP_AW'(1);
                    end
                    default: ;
                endcase
                if (sel.act == ACT_HALT) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    d.base  = sel.next_base;
                    d.id    = sel.next_id;
                    d.wcode = sel.wcode;
                    d.state = ST_RUN;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done      = q.done;
    assign underflow = q.uf;
    assign sp_we     = q.sp_we;
    assign sp_addr   = q.sp_addr;
    assign sp_data   = q.sp_data;
endmodule

// File: rtl/dl_checker.sv
module dl_checker #(
    parameter int SP_AW = 6,
    parameter int CNT_W = 5,
    parameter int BUF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             take,
    input logic             in_act,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             in_ready,
    input logic             done,
    input logic             underflow,
    input logic             sp_we,
    input logic [SP_AW-1:0] sp_addr
);
    logic [SP_AW-1:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                wcnt <= '0;
        else if (start && !busy)   wcnt <= '0;
        else if (sp_we)            wcnt <= wcnt + SP_AW'(1);
    end

    assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> in_act);

    assert_buffer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BUF_W));

    assert_ready_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && bit_cnt <= CNT_W'(BUF_W - 8)));

    assert_store_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (sp_addr == wcnt));

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sp_we && !in_ready && !busy));

    assert_underflow_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (!done && !in_ready && !busy && !sp_we));

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !underflow));
endmodule

bind dispatch_lane dl_checker #(.SP_AW(SP_AW), .CNT_W(CNT_W), .BUF_W(BUF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .take(take),
    .in_act(in_act), .bit_cnt(bit_cnt), .in_ready(in_ready), .done(done),
    .underflow(underflow), .sp_we(sp_we), .sp_addr(sp_addr)
);

// File: tb/tb_dispatch_lane.sv
module tb_dispatch_lane;
    localparam int DATA_W = 8;
    localparam int SP_AW  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [20:0] ld_word = '0;
    logic start = 1'b0;
    logic done, underflow, in_ready, sp_we;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_last = 1'b0;
    logic [SP_AW-1:0] sp_addr;
    logic [DATA_W-1:0] sp_data;

    always #4 clk = ~clk;

    dispatch_lane #(.DATA_W(DATA_W), .SP_AW(SP_AW)) dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_word(ld_word),
        .start(start), .done(done), .underflow(underflow),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .sp_we(sp_we), .sp_addr(sp_addr), .sp_data(sp_data)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [13:0] exp_q[$];
    int stamps[$];
    bit bits[$];
    int mreg;
    int mptr;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && sp_we) begin
            stamps.push_back(cyc);
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected scratchpad write addr", int'(sp_addr), -1);
            end else begin
                logic [13:0] e;
                e = exp_q.pop_front();
                check(sp_addr == e[13:8], "R6", "write address", int'(sp_addr), int'(e[13:8]));
                check(sp_data == e[7:0], "R1", "write data", int'(sp_data), int'(e[7:0]));
            end
        end
    end

    function automatic logic [20:0] mk(input int sig, input int nbase, input int nid,
                                        input int wc, input int act);
        return {3'(act), 2'(wc), 4'(nid), 8'(nbase), 4'(sig)};
    endfunction

    task automatic put(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) bits.push_back(v[i]);
    endtask

    task automatic new_run();
        bits.delete();
        stamps.delete();
        mreg = 0;
        mptr = 0;
    endtask

    task automatic runs(input int k);
        for (int i = 0; i < k; i++) begin
            put(1, 1);
            exp_q.push_back({6'(mptr), 8'(mreg)});
            mptr++;
        end
        put(0, 1);
    endtask

    // tag 0 literal, tag 2 has no entry of its own (falls back to default)
    task automatic lit(input int v, input int k, input bit via_miss);
        put(via_miss ? 2 : 0, 2);
        put(v, 8);
        mreg = v & 255;
        runs(k);
    endtask

    task automatic delta(input int dv, input int k);
        put(1, 2);
        put(dv, 4);
        mreg = (mreg + dv) & 255;
        runs(k);
    endtask

    task automatic finish_tag();
        put(3, 2);
    endtask

    task automatic run_stream(output bit timed_out);
        int nb;
        logic [7:0] bytes[];
        int i;
        int t;
        nb = (bits.size() + 7) / 8;
        bytes = new[nb];
        for (int b = 0; b < nb; b++) begin
            bytes[b] = '0;
            for (int j = 0; j < 8; j++)
                if (b * 8 + j < bits.size()) bytes[b][7-j] = bits[b*8+j];
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        i = 0;
        t = 0;
        while (i < nb && !done && !underflow && t < 5000) begin
            in_valid = 1'b1;
            in_data  = bytes[i];
            in_last  = (i == nb - 1);
            if (in_ready) i++;
            @(negedge clk);
            t++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (!done && !underflow && t < 5000) begin
            @(negedge clk);
            t++;
        end
        timed_out = (t >= 5000);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        bit to;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(done == 1'b0, "R9", "done after reset", int'(done), 0);
        check(underflow == 1'b0, "R9", "underflow after reset", int'(underflow), 0);
        check(in_ready == 1'b0, "R9", "in_ready after reset", int'(in_ready), 0);
        check(sp_we == 1'b0, "R9", "sp_we after reset", int'(sp_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table load: clear everything, then the run-length expander
        for (int a = 0; a < 256; a++) begin
            ld_we = 1'b1; ld_addr = 8'(a); ld_word = '0;
            @(negedge clk);
        end
        ld_addr = 8'd0; ld_word = mk(0, 6, 1, 3, 0); @(negedge clk); // tag 0 -> value state
        ld_addr = 8'd1; ld_word = mk(0, 2, 3, 2, 0); @(negedge clk); // tag 1 -> delta state
        ld_addr = 8'd2; ld_word = mk(3, 4, 2, 0, 2); @(negedge clk); // delta default: add (interleaved)
        ld_addr = 8'd3; ld_word = mk(0, 0, 0, 0, 4); @(negedge clk); // tag 3 -> halt
        ld_addr = 8'd4; ld_word = mk(2, 0, 0, 1, 0); @(negedge clk); // run bit 0 -> tag state
        ld_addr = 8'd5; ld_word = mk(2, 4, 2, 0, 3); @(negedge clk); // run bit 1 -> store, stay
        ld_addr = 8'd6; ld_word = mk(1, 4, 2, 0, 1); @(negedge clk); // value default: load
        ld_we = 1'b0;
        @(negedge clk);

        // T1: literals, runs, add with wrap, signature miss, halt
        new_run();
        lit(8'h5A, 3, 1'b0);
        lit(8'hC3, 1, 1'b0);
        delta(4, 2);
        lit(8'hFF, 0, 1'b0);
        delta(15, 1);            // R6: 0xFF + 15 wraps to 0x0E
        lit(8'h21, 2, 1'b1);     // R2: tag 2 misses, default at base + 0
        lit(8'hFA, 1, 1'b0);     // R1: value whose address wraps past 255
        finish_tag();
        run_stream(to);
        check(!to, "R7", "run 1 completed", int'(to), 0);
        check(exp_q.size() == 0, "R1", "pending expected writes run 1", exp_q.size(), 0);
        check(done == 1'b1, "R7", "done after halt", int'(done), 1);
        check(underflow == 1'b0, "R8", "no underflow on halt", int'(underflow), 0);
        check(in_ready == 1'b0, "R7", "in_ready after halt", int'(in_ready), 0);
        repeat (6) @(negedge clk);
        check(done == 1'b1, "R7", "done held", int'(done), 1);
        exp_q.delete();

        // T2: restart clears register and write address (R10)
        new_run();
        delta(7, 2);
        lit(8'h80, 1, 1'b0);
        finish_tag();
        run_stream(to);
        check(exp_q.size() == 0, "R10", "pending expected writes run 2", exp_q.size(), 0);
        check(done == 1'b1, "R10", "done after run 2", int'(done), 1);
        exp_q.delete();

        // T3: constant dispatch latency on a long run of stores (R3, R4)
        new_run();
        lit(8'h3C, 8, 1'b0);
        finish_tag();
        run_stream(to);
        check(stamps.size() == 8, "R3", "store count", stamps.size(), 8);
        for (int g = 1; g < stamps.size(); g++)
            check(stamps[g] - stamps[g-1] == 2, "R3", "cycles between stores",
                  stamps[g] - stamps[g-1], 2);
        exp_q.delete();

        // T4: stream ends without halt (R8)
        new_run();
        lit(8'h11, 1, 1'b0);
        run_stream(to);
        check(exp_q.size() == 0, "R8", "pending expected writes run 4", exp_q.size(), 0);
        check(underflow == 1'b1, "R8", "underflow raised", int'(underflow), 1);
        check(done == 1'b0, "R8", "done low on underflow", int'(done), 0);
        repeat (6) @(negedge clk);
        check(in_ready == 1'b0, "R5", "in_ready low when idle", int'(in_ready), 0);
        check(underflow == 1'b1, "R8", "underflow held", int'(underflow), 1);

        summary();
    end
endmodule